// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block owns the program counter of a simple single-issue core and chooses its value for the next cycle. The current PC drives the instruction memory address. Each cycle the unit looks at the fetched instruction word, the ALU zero flag and two select lines from the main decoder (branch request and jump request). From these it takes one of three next-PC sources: sequential (PC + 4), a PC-relative conditional branch, or an absolute jump that stays within the current 256 MB region.

The selector works like a small state machine over three named sources. SEQ is the default. It moves to BRANCH when the branch request and the zero flag are both high. It moves to JUMP whenever the jump request is high, whatever the branch path says. The PC is stored as a word index, so fetch addresses always stay word-aligned. The unit also decodes the jump opcode from the top six instruction bits. The decoder can use this to drive the jump request.

Top module: `pc_fetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `pc` becomes 0x00000000 after that edge. This holds even if jump or branch is requested.
- R2: With `branch_req` and `jump_req` both low, `pc` advances by 4 at each rising edge.
- R3: With `branch_req` and `alu_zero` both high and `jump_req` low, the next `pc` is `pc + 4 + (sign-extended instr[15:0] * 4)`.
- R4: With `branch_req` high and `alu_zero` low, the next `pc` is `pc + 4`.
- R5: `alu_zero` alone, without `branch_req`, has no effect: the next `pc` is `pc + 4`.
- R6: With `jump_req` high, the next `pc` is `{pc[31:28], instr[25:0], 2'b00}`. This takes priority over a taken branch.
- R7: `pc[1:0]` is always 2'b00.
- R8: `jump_op` is high, in the same cycle, exactly when `instr[31:26]` equals 6'b000010.
- R9: Branch arithmetic wraps modulo 2^32, so a negative offset from a small PC lands near the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word |
| alu_zero | input | 1 | ALU zero flag from the compare |
| branch_req | input | 1 | Branch / not-branch select from the decoder |
| jump_req | input | 1 | Jump select from the decoder |
| pc | output | 32 | Program counter (instruction memory address) |
| jump_op | output | 1 | Opcode field matches the jump opcode |

## Verification
A change to `pc` is due one rising edge after its inputs are applied, because a single register stands between inputs and `pc`. The bench therefore drives inputs after a falling edge and compares `pc` with its model at the next falling edge. `jump_op` is combinational, so it is sampled one time unit after `instr` changes, inside the same cycle. Reset is checked both at start-up and in mid-run, with a jump request present.

// File: rtl/pc_fetch_pkg.sv
package pc_fetch_pkg;

    // Named next-PC sources chosen each cycle.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/pc_opcode_match.sv
// Compares the opcode field to a fixed pattern: bitwise XNOR then AND reduce.
module pc_opcode_match #(
    parameter int          OPC_W   = 6,
    parameter logic [5:0]  PATTERN = 6'b000010
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             hit
);
    logic [OPC_W-1:0] bit_eq;

    for (genvar i = 0; i < OPC_W; i++) begin : g_bit
        assign bit_eq[i] = ~(opcode[i] ^ PATTERN[i]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/pc_target_gen.sv
// Produces the three candidate next-PC values in word units.
module pc_target_gen #(
    parameter int WORD_W = 30,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input  logic [WORD_W-1:0] pc_word,
    input  logic [IMM_W-1:0]  imm,
    input  logic [TGT_W-1:0]  target,
    output logic [WORD_W-1:0] seq_word,
    output logic [WORD_W-1:0] br_word,
    output logic [WORD_W-1:0] jmp_word
);
    localparam int EXT_W    = WORD_W - IMM_W;
    localparam int REGION_W = WORD_W - TGT_W;

    logic [WORD_W-1:0] imm_ext;

    assign imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign seq_word = pc_word + WORD_W'(1);
    assign br_word  = seq_word + imm_ext;
    assign jmp_word = {pc_word[WORD_W-1 -: REGION_W], target};
endmodule

// File: rtl/pc_src_select.sv
// Chooses the next-PC source; jump outranks branch.
module pc_src_select
    import pc_fetch_pkg::*;
(
    input  logic     branch_req,
    input  logic     alu_zero,
    input  logic     jump_req,
    output npc_src_e src
);
    always_comb begin
        if (jump_req)
            src = SRC_JUMP;
        else if (branch_req && alu_zero)
            src = SRC_BRANCH;
        else
            src = SRC_SEQ;
    end
endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit
    import pc_fetch_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              IMM_W    = 16,
    parameter int              TGT_W    = 26,
    parameter int              OPC_W    = 6,
    parameter logic [5:0]      JUMP_OPC = 6'b000010,
    parameter logic [31:0]     RESET_PC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr,
    input  logic              alu_zero,
    input  logic              branch_req,
    input  logic              jump_req,
    output logic [ADDR_W-1:0] pc,
    output logic              jump_op
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] pc_word;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] seq_word;
    logic [WORD_W-1:0] br_word;
    logic [WORD_W-1:0] jmp_word;
    npc_src_e          src;

    pc_opcode_match #(
        .OPC_W   (OPC_W),
        .PATTERN (JUMP_OPC)
    ) u_jdec (
        .opcode (instr[31 -: OPC_W]),
        .hit    (jump_op)
    );

    pc_target_gen #(
        .WORD_W (WORD_W),
        .IMM_W  (IMM_W),
        .TGT_W  (TGT_W)
    ) u_tgt (
        .pc_word  (pc_word),
        .imm      (instr[IMM_W-1:0]),
        .target   (instr[TGT_W-1:0]),
        .seq_word (seq_word),
        .br_word  (br_word),
        .jmp_word (jmp_word)
    );

    pc_src_select u_sel (
        .branch_req (branch_req),
        .alu_zero   (alu_zero),
        .jump_req   (jump_req),
        .src        (src)
    );

    always_comb begin
        unique case (src)
            SRC_SEQ:    next_word = seq_word;
            SRC_BRANCH: next_word = br_word;
            SRC_JUMP:   next_word = jmp_word;
            default:    next_word = seq_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_word <= RESET_PC[ADDR_W-1:2];
        else
            pc_word <= next_word;
    end

    assign pc = {pc_word, 2'b00};
endmodule

// File: rtl/pc_fetch_chk.sv
module pc_fetch_chk #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input logic              clk,
    input logic              rst,
    input logic [TGT_W-1:0]  instr_lo,
    input logic              alu_zero,
    input logic              branch_req,
    input logic              jump_req,
    input logic [ADDR_W-1:0] pc
);
    localparam int REGION_W = ADDR_W - TGT_W - 2;

    logic              seen = 1'b0;
    logic [ADDR_W-1:0] off_bytes;

    always_ff @(posedge clk) seen <= 1'b1;

    assign off_bytes = {{(ADDR_W-IMM_W){instr_lo[IMM_W-1]}}, instr_lo[IMM_W-1:0]} << 2;

    // R1
    a_r1_sync_reset: assert property (@(posedge clk) disable iff (!seen)
        $past(rst) |-> pc == '0);

    // R2, R5
    a_r2_sequential: assert property (@(posedge clk) disable iff (rst || !seen)
        (!$past(rst) && !$past(jump_req) && !$past(branch_req))
        |-> pc == $past(pc) + ADDR_W'(4));

    // R3, R9
    a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst || !seen)
        (!$past(rst) && !$past(jump_req) && $past(branch_req) && $past(alu_zero))
        |-> pc == $past(pc) + ADDR_W'(4) + $past(off_bytes));

    // R4
    a_r4_branch_not_taken: assert property (@(posedge clk) disable iff (rst || !seen)
        (!$past(rst) && !$past(jump_req) && $past(branch_req) && !$past(alu_zero))
        |-> pc == $past(pc) + ADDR_W'(4));

    // R6
    a_r6_jump_region: assert property (@(posedge clk) disable iff (rst || !seen)
        (!$past(rst) && $past(jump_req))
        |-> pc == {$past(pc[ADDR_W-1 -: REGION_W]), $past(instr_lo), 2'b00});
endmodule

bind pc_fetch_unit pc_fetch_chk #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_lo   (instr[TGT_W-1:0]),
    .alu_zero   (alu_zero),
    .branch_req (branch_req),
    .jump_req   (jump_req),
    .pc         (pc)
);

// File: tb/sim_pc_fetch_unit.sv
`timescale 1ns/1ps
module sim_pc_fetch_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        alu_zero;
    logic        branch_req;
    logic        jump_req;
    logic [31:0] pc;
    logic        jump_op;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_pc;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_fetch_unit u0 (
        .clk(clk), .rst(rst), .instr(instr), .alu_zero(alu_zero),
        .branch_req(branch_req), .jump_req(jump_req), .pc(pc), .jump_op(jump_op)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, let one edge pass, compare with the model.
    task automatic step(input string req, input logic r, input logic [31:0] ins,
                        input logic z, input logic br, input logic j);
        logic [31:0] expv;
        int off;
        rst = r; instr = ins; alu_zero = z; branch_req = br; jump_req = j;
        #1;
        check("R8", {31'd0, jump_op}, {31'd0, ins[31:26] == 6'd2});
        off = $signed(ins[15:0]);
        if (r)               expv = 32'h0;
        else if (j)          expv = {model_pc[31:28], ins[25:0], 2'b00};
        else if (br && z)    expv = model_pc + 32'd4 + 32'(off * 4);
        else                 expv = model_pc + 32'd4;
        @(posedge clk);
        @(negedge clk);
        model_pc = expv;
        check(req, pc, expv);
        check("R7", {30'd0, pc[1:0]}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_pc = 32'h0;
        rst = 1'b1; instr = '0; alu_zero = 1'b0; branch_req = 1'b0; jump_req = 1'b0;
        @(negedge clk);
        step("R1", 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        // R2 plain sequence
        for (int i = 0; i < 3; i++) step("R2", 1'b0, 32'h0123_4567, 1'b0, 1'b0, 1'b0);
        // R5 zero without branch request
        step("R5", 1'b0, 32'h1000_0010, 1'b1, 1'b0, 1'b0);
        // R3 taken forward branch, offset +16 words
        step("R3", 1'b0, 32'h1000_0010, 1'b1, 1'b1, 1'b0);
        // R4 branch not taken
        step("R4", 1'b0, 32'h1000_0010, 1'b0, 1'b1, 1'b0);
        // R3 taken backward branch, offset -3 words
        step("R3", 1'b0, 32'h1000_FFFD, 1'b1, 1'b1, 1'b0);
        // R6 jump with a taken branch also presented
        step("R6", 1'b0, 32'h0800_0003, 1'b1, 1'b1, 1'b1);
        // R9 wrap: pc 0x0C, offset -5 words -> 0xFFFFFFFC
        step("R9", 1'b0, 32'h1000_FFFB, 1'b1, 1'b1, 1'b0);
        // R6 jump keeps region 0xF
        step("R6", 1'b0, 32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1);
        step("R2", 1'b0, 32'h0C00_0000, 1'b0, 1'b0, 1'b0);
        // R8 opcode neighbours
        step("R2", 1'b0, 32'h8800_0000, 1'b0, 1'b0, 1'b0);
        // R1 reset in mid-run overrides a jump
        step("R1", 1'b1, 32'h0812_3456, 1'b1, 1'b1, 1'b1);
        step("R6", 1'b0, 32'h0812_3456, 1'b0, 1'b0, 1'b1);
        step("R2", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule